// File: doc/BRIEF.md
# Class Score Accumulation and Winner Selection

This block is the back end of a per-pixel probabilistic classifier. Upstream logic delivers one exponential term per stored weight. The terms arrive class by class, and a flag marks the final weight of each class. The block sums the terms of the current class into a wide accumulator. When a class closes, the sum is multiplied by a per-class constant that the host has loaded. The constants are normalised so that the largest is exactly one. The scaled result is the class score.

A running maximum is kept across the classes of one pixel. When the final class of the pixel has been scored, the block presents the index of the best class and pulses a done strobe for one cycle. The host sets the number of classes through a small count register. It writes the class constants into a 16-entry table before a run starts.

Top module: `class_score_argmax`

## Requirements
- R1: After reset, `done_o` is 0, `class_o` is 0 and the class count register holds 0.
- R2: Terms and constants are unsigned fixed point with 31 fraction bits, so 1.0 is 0x8000_0000. The accumulator is 40 bits wide. A class score is bits [70:31] of the 72-bit product of the 40-bit class sum and the 32-bit constant of that class.
- R3: The accumulator starts every class at zero. Terms of one class never add into the sum of the next class.
- R4: The classes of a pixel are numbered 0, 1, 2 and so on, in arrival order. Class n is scaled by the constant at table address n.
- R5: The reported class is the one with the largest score. When two scores are equal, the lower class index wins.
- R6: `done_o` is high for exactly one cycle, two clock edges after the edge that accepts the last-flagged term of the final class. `class_o` holds the winner until the next done strobe.
- R7: A write with `ncls_we_i` loads the class count from `ncls_i`. A count of n means n classes per pixel, and a count of 0 means 16 classes. `done_o` stays low until the final class of the pixel closes.
- R8: The running maximum restarts with class 0 of each pixel. Scores from an earlier pixel never affect the winner of a later one.
- R9: While `term_vld_i` is low, `term_i` and `term_last_i` are ignored.
- R10: A constant written with `cst_we_i` at address `cst_addr_i` is used for every later class that has that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| term_vld_i | input | 1 | Exponential term valid |
| term_i | input | 32 | Exponential term, 31 fraction bits |
| term_last_i | input | 1 | Term is the last weight of its class |
| cst_we_i | input | 1 | Class constant write enable |
| cst_addr_i | input | 4 | Class constant address |
| cst_data_i | input | 32 | Class constant, 31 fraction bits |
| ncls_we_i | input | 1 | Class count write enable |
| ncls_i | input | 4 | Class count (0 means 16) |
| class_o | output | 4 | Index of the winning class |
| done_o | output | 1 | Winner valid, one-cycle pulse |

## Verification
A table of hashed pixels checks the main path against a reference model written from R2 and R5. The pixels cover 1, 2, 3, 5, 7 and 16 classes and 1 to 15 weights per class, with unequal constants. A wrong product slice or a wrong class count gives a different winner there.

Directed pixels then separate the individual mechanisms:
- Equal scores show that the tie rule holds.
- A small class followed by a smaller one shows that the accumulator clears between classes.
- A strong pixel followed by a weak one shows that the running maximum clears between pixels.
- A halved constant that flips the winner shows that each class reads its own table entry and that a rewrite of that entry takes effect.
- Idle cycles that carry large, last-flagged garbage terms show that the valid signal gates the input.

// File: rtl/cls_pkg.sv
package cls_pkg;
  parameter int TERM_W = 32;
  parameter int CST_W  = 32;
  parameter int ACC_W  = 40;
  parameter int FRAC_W = 31;
  parameter int ID_W   = 4;
  localparam int NUM_CLS = 1 << ID_W;
  localparam int PROD_W  = ACC_W + CST_W;
endpackage

// File: rtl/cls_acc.sv
module cls_acc #(
  parameter int TERM_W = cls_pkg::TERM_W,
  parameter int ACC_W  = cls_pkg::ACC_W,
  parameter int ID_W   = cls_pkg::ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              term_vld_i,
  input  logic [TERM_W-1:0] term_i,
  input  logic              term_last_i,
  input  logic [ID_W-1:0]   last_idx_i,
  output logic              sum_vld_o,
  output logic [ACC_W-1:0]  sum_o,
  output logic [ID_W-1:0]   sum_cls_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ID_W-1:0]  idx_q;
  logic [ACC_W:0]   wide_sum;

  assign wide_sum = {1'b0, acc_q} + (ACC_W+1)'(term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      idx_q     <= '0;
      sum_vld_o <= 1'b0;
      sum_o     <= '0;
      sum_cls_o <= '0;
    end else begin
      sum_vld_o <= 1'b0;
      if (term_vld_i) begin
        if (term_last_i) begin
          sum_o     <= wide_sum[ACC_W-1:0];
          sum_vld_o <= 1'b1;
          sum_cls_o <= idx_q;
          acc_q     <= '0;
          idx_q     <= (idx_q == last_idx_i) ? '0 : idx_q + ID_W'(1);
        end else begin
          acc_q <= wide_sum[ACC_W-1:0];
        end
      end
    end
  end

  // R2
  acc_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_vld_i |-> !wide_sum[ACC_W]);

  // R3
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_vld_i && term_last_i) |=> (acc_q == '0));
endmodule

// File: rtl/cls_scale.sv
module cls_scale #(
  parameter int ACC_W  = cls_pkg::ACC_W,
  parameter int CST_W  = cls_pkg::CST_W,
  parameter int FRAC_W = cls_pkg::FRAC_W,
  parameter int ID_W   = cls_pkg::ID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cst_we_i,
  input  logic [ID_W-1:0]  cst_addr_i,
  input  logic [CST_W-1:0] cst_data_i,
  input  logic             sum_vld_i,
  input  logic [ACC_W-1:0] sum_i,
  input  logic [ID_W-1:0]  sum_cls_i,
  output logic             score_vld_o,
  output logic [ACC_W-1:0] score_o,
  output logic [ID_W-1:0]  score_cls_o
);
  localparam int NUM    = 1 << ID_W;
  localparam int PROD_W = ACC_W + CST_W;
  localparam logic [CST_W-1:0] CST_ONE = CST_W'(1) << FRAC_W;

  logic [CST_W-1:0]  cst_q [NUM];
  logic [CST_W-1:0]  cst_rd;
  logic [PROD_W-1:0] prod;
  logic              unused_lo;

  assign cst_rd    = cst_q[sum_cls_i];
  assign prod      = PROD_W'(sum_i) * PROD_W'(cst_rd);
  assign unused_lo = ^prod[FRAC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM; i++) cst_q[i] <= '0;
    end else if (cst_we_i) begin
      cst_q[cst_addr_i] <= cst_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      score_vld_o <= 1'b0;
      score_o     <= '0;
      score_cls_o <= '0;
    end else begin
      score_vld_o <= sum_vld_i;
      if (sum_vld_i) begin
        score_o     <= prod[FRAC_W +: ACC_W];
        score_cls_o <= sum_cls_i;
      end
    end
  end

  // R2
  prod_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_vld_i && cst_rd <= CST_ONE) |-> !prod[PROD_W-1]);

  // R2
  score_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_vld_i && cst_rd <= CST_ONE) |=> (score_o <= $past(sum_i)));
endmodule

// File: rtl/cls_argmax.sv
module cls_argmax #(
  parameter int ACC_W = cls_pkg::ACC_W,
  parameter int ID_W  = cls_pkg::ID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             score_vld_i,
  input  logic [ACC_W-1:0] score_i,
  input  logic [ID_W-1:0]  score_cls_i,
  input  logic [ID_W-1:0]  last_idx_i,
  output logic [ID_W-1:0]  class_o,
  output logic             done_o
);
  logic [ACC_W-1:0] best_q, best_nxt;
  logic [ID_W-1:0]  best_idx_q, idx_nxt;
  logic             take;

  // strict compare keeps the lower index on ties; class 0 restarts the max
  always_comb begin
    take     = (score_cls_i == '0) || (score_i > best_q);
    best_nxt = take ? score_i : best_q;
    idx_nxt  = take ? score_cls_i : best_idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_q     <= '0;
      best_idx_q <= '0;
      class_o    <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (score_vld_i) begin
        best_q     <= best_nxt;
        best_idx_q <= idx_nxt;
        if (score_cls_i == last_idx_i) begin
          class_o <= idx_nxt;
          done_o  <= 1'b1;
        end
      end
    end
  end

  // R5
  max_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (score_vld_i && score_cls_i != '0) |=> (best_q >= $past(best_q)));

  // R7
  winner_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (class_o <= $past(last_idx_i)));
endmodule

// File: rtl/class_score_argmax.sv
module class_score_argmax #(
  parameter int TERM_W = cls_pkg::TERM_W,
  parameter int CST_W  = cls_pkg::CST_W,
  parameter int ACC_W  = cls_pkg::ACC_W,
  parameter int FRAC_W = cls_pkg::FRAC_W,
  parameter int ID_W   = cls_pkg::ID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              term_vld_i,
  input  logic [TERM_W-1:0] term_i,
  input  logic              term_last_i,
  input  logic              cst_we_i,
  input  logic [ID_W-1:0]   cst_addr_i,
  input  logic [CST_W-1:0]  cst_data_i,
  input  logic              ncls_we_i,
  input  logic [ID_W-1:0]   ncls_i,
  output logic [ID_W-1:0]   class_o,
  output logic              done_o
);
  logic [ID_W-1:0]  ncls_q, last_idx;
  logic             sum_vld, score_vld;
  logic [ACC_W-1:0] sum, score;
  logic [ID_W-1:0]  sum_cls, score_cls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ncls_q <= '0;
    else if (ncls_we_i) ncls_q <= ncls_i;
  end

  // count 0 wraps to the top index, giving the full class set
  assign last_idx = ncls_q - ID_W'(1);

  cls_acc #(.TERM_W(TERM_W), .ACC_W(ACC_W), .ID_W(ID_W)) u_acc (
    .clk_i, .rst_ni,
    .term_vld_i, .term_i, .term_last_i,
    .last_idx_i(last_idx),
    .sum_vld_o(sum_vld), .sum_o(sum), .sum_cls_o(sum_cls)
  );

  cls_scale #(.ACC_W(ACC_W), .CST_W(CST_W), .FRAC_W(FRAC_W), .ID_W(ID_W)) u_scale (
    .clk_i, .rst_ni,
    .cst_we_i, .cst_addr_i, .cst_data_i,
    .sum_vld_i(sum_vld), .sum_i(sum), .sum_cls_i(sum_cls),
    .score_vld_o(score_vld), .score_o(score), .score_cls_o(score_cls)
  );

  cls_argmax #(.ACC_W(ACC_W), .ID_W(ID_W)) u_argmax (
    .clk_i, .rst_ni,
    .score_vld_i(score_vld), .score_i(score), .score_cls_i(score_cls),
    .last_idx_i(last_idx),
    .class_o, .done_o
  );
endmodule

// File: tb/class_score_argmax_test.sv
module class_score_argmax_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        term_vld, term_last, cst_we, ncls_we;
  logic [31:0] term, cst_data;
  logic [3:0]  cst_addr, ncls;
  logic [3:0]  class_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] cst_m  [16];
  logic [31:0] cust_t [16];

  // fields: class count (0 = 16), weights per class, hash seed
  localparam logic [39:0] VEC [6] = '{
    {4'd3, 4'd4,  32'h1234_5678},
    {4'd1, 4'd2,  32'hCAFE_0001},
    {4'd0, 4'd3,  32'h0BAD_F00D},
    {4'd7, 4'd15, 32'h5555_AAAA},
    {4'd5, 4'd1,  32'h0000_0042},
    {4'd2, 4'd8,  32'hFEED_BEEF}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  class_score_argmax uut (
    .clk_i(clk), .rst_ni(rst_n),
    .term_vld_i(term_vld), .term_i(term), .term_last_i(term_last),
    .cst_we_i(cst_we), .cst_addr_i(cst_addr), .cst_data_i(cst_data),
    .ncls_we_i(ncls_we), .ncls_i(ncls),
    .class_o(class_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] hterm(input logic [31:0] s, input int c, input int w);
    logic [31:0] h;
    h = s ^ (32'(c) * 32'h85EB_CA6B) ^ (32'(w + 1) * 32'hC2B2_AE35);
    h = h ^ (h >> 13);
    h = h * 32'h9E37_79B1;
    h = h ^ (h >> 16);
    return {1'b0, h[30:0]};
  endfunction

  function automatic logic [31:0] tval(input bit cust, input logic [31:0] s,
                                       input int c, input int w);
    return cust ? cust_t[c] : hterm(s, c, w);
  endfunction

  // reference model from R2 and R5
  function automatic logic [3:0] model(input int nc, input int nt,
                                       input logic [31:0] s, input bit cust);
    logic [39:0] best, sum, sc;
    logic [71:0] p;
    logic [3:0]  win;
    best = '0; win = '0;
    for (int c = 0; c < nc; c++) begin
      sum = '0;
      for (int w = 0; w < nt; w++) sum = sum + 40'(tval(cust, s, c, w));
      p  = 72'(sum) * 72'(cst_m[c]);
      sc = p[70:31];
      if (c == 0 || sc > best) begin best = sc; win = 4'(c); end
    end
    return win;
  endfunction

  task automatic wr_cst(input int a, input logic [31:0] d);
    @(negedge clk);
    cst_we = 1'b1; cst_addr = 4'(a); cst_data = d;
    cst_m[a] = d;
    @(negedge clk);
    cst_we = 1'b0;
  endtask

  task automatic run_pixel(input logic [3:0] nraw, input int nt, input logic [31:0] s,
                           input bit cust, input bit gaps, input string req);
    int nc;
    logic [3:0] exp;
    bit early;
    nc    = (nraw == 4'd0) ? 16 : int'(nraw);
    exp   = model(nc, nt, s, cust);
    early = 1'b0;
    @(negedge clk);
    ncls_we = 1'b1; ncls = nraw;
    @(negedge clk);
    ncls_we = 1'b0;
    for (int c = 0; c < nc; c++) begin
      for (int w = 0; w < nt; w++) begin
        if (gaps) begin
          // R9: large last-flagged garbage while valid is low
          term_vld = 1'b0; term = 32'h7FFF_FFFF; term_last = 1'b1;
          @(negedge clk);
          if (done_o) early = 1'b1;
        end
        term_vld = 1'b1; term = tval(cust, s, c, w); term_last = (w == nt - 1);
        @(negedge clk);
        if (done_o) early = 1'b1;
      end
    end
    term_vld = 1'b0; term_last = 1'b0; term = '0;
    chk(!early && !done_o, "R7", {req, " no early done"}, 64'(done_o), 0);
    @(negedge clk);
    chk(!done_o, "R6", {req, " done not yet"}, 64'(done_o), 0);
    @(negedge clk);
    chk(done_o == 1'b1, "R6", {req, " done strobe"}, 64'(done_o), 1);
    chk(class_o == exp, "R5", {req, " winner"}, 64'(class_o), 64'(exp));
    @(negedge clk);
    chk(!done_o && class_o == exp, "R6", {req, " one-cycle strobe, class held"},
        64'({done_o, class_o}), 64'({1'b0, exp}));
  endtask

  initial begin
    rst_n = 1'b0; term_vld = 1'b0; term = '0; term_last = 1'b0;
    cst_we = 1'b0; cst_addr = '0; cst_data = '0; ncls_we = 1'b0; ncls = '0;
    for (int i = 0; i < 16; i++) begin cst_m[i] = '0; cust_t[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!done_o && class_o == 4'd0, "R1", "reset outputs",
        64'({done_o, class_o}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) wr_cst(i, 32'h8000_0000 - 32'(i) * 32'h0300_0000);

    // R2 R4 R7: table of hashed pixels
    for (int v = 0; v < 6; v++)
      run_pixel(VEC[v][39:36], int'(VEC[v][35:32]), VEC[v][31:0], 1'b0, 1'b0, "R2 table");

    // R5: tie goes to lower index
    wr_cst(1, 32'h8000_0000);
    cust_t[0] = 32'h4000_0000; cust_t[1] = 32'h4000_0000;
    run_pixel(4'd2, 3, '0, 1'b1, 1'b0, "R5 tie");
    cust_t[1] = 32'h4000_0001;
    run_pixel(4'd2, 3, '0, 1'b1, 1'b0, "R5 higher index larger");

    // R3: accumulator must not carry class 0 into class 1
    cust_t[0] = 32'h1000_0000; cust_t[1] = 32'h0800_0000;
    run_pixel(4'd2, 1, '0, 1'b1, 1'b0, "R3 clear between classes");

    // R8: strong pixel then weak pixel
    cust_t[0] = 32'h0100_0000; cust_t[1] = 32'h7000_0000;
    run_pixel(4'd2, 2, '0, 1'b1, 1'b0, "R8 strong pixel");
    cust_t[0] = 32'h2000_0000; cust_t[1] = 32'h1000_0000;
    run_pixel(4'd2, 2, '0, 1'b1, 1'b0, "R8 weak pixel");

    // R4 R10: halved constant flips the winner, rewrite restores it
    wr_cst(0, 32'h4000_0000);
    cust_t[0] = 32'h6000_0000; cust_t[1] = 32'h5000_0000;
    run_pixel(4'd2, 2, '0, 1'b1, 1'b0, "R4 constant per class");
    wr_cst(0, 32'h8000_0000);
    run_pixel(4'd2, 2, '0, 1'b1, 1'b0, "R10 constant rewrite");

    // R9: idle cycles with garbage
    cust_t[0] = 32'h3000_0000; cust_t[1] = 32'h2000_0000; cust_t[2] = 32'h2800_0000;
    run_pixel(4'd3, 2, '0, 1'b1, 1'b1, "R9 valid low ignored");

    // R7: all 16 classes with gaps
    run_pixel(4'd0, 2, 32'h7777_1111, 1'b0, 1'b1, "R7 sixteen classes");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule